// File: doc/BRIEF.md
# I2C Target Controller with Double-Buffered Receive

This block is the target side of a two-wire serial bus. It watches the clock and data lines through synchronisers and detects bus start and stop conditions from them. It compares incoming address bytes against a programmed address in either 7-bit or 10-bit form. The general call address can also be accepted if that option is enabled. The block acknowledges a matching address and then moves data bytes in either direction. The pads are open-drain, so the block only ever pulls a line low: `scl_oe` and `sda_oe` high mean "drive the line to zero".

A host reaches the block through four byte-wide registers, selected by `reg_sel`:

| `reg_sel` | Register |
|---|---|
| 0 | Data buffer |
| 1 | Own address (low 8 bits) |
| 2 | Control |
| 3 | Status |

Received bytes are shifted into a shift register. When a byte is complete, it is copied into the data buffer, the buffer-full flag is set and the interrupt flag is raised. Transmission has no second buffer: a host write to the data buffer loads the buffer and the shift register in the same cycle. In transmit mode the block holds SCL low after each acknowledged byte, until the host has supplied the next byte.

Control register bits:

| Bit | Meaning |
|---|---|
| 0 | Enable |
| 1 | 10-bit mode |
| 2 | General call accept |
| 4:3 | Upper two bits of the 10-bit address |

Status register bits:

| Bit | Meaning |
|---|---|
| 0 | Buffer full |
| 1 | Transmit direction |
| 2 | Last byte was data (0 = address) |
| 3 | START seen |
| 4 | STOP seen |
| 5 | General call hit |
| 6 | Interrupt flag |
| 7 | Overflow |

Top module: `i2c_target_ctrl`

## Requirements
- R1: After reset, all status bits read 0, `irq` is 0, and neither line is driven. A START sets status bit 3 and clears bit 4. A STOP sets bit 4 and clears bit 3. The two bits are never 1 together, and the block drives a line only while bit 3 is 1.
- R2: In 7-bit mode (control bit 1 = 0), an address byte whose upper seven bits equal own-address bits 6:0 is acknowledged: SDA is held low during the ninth clock. Any other byte gets no acknowledge. Address bit 0 selects the direction: 1 means the target transmits.
- R3: The byte 0x00 is acknowledged as a general call only when control bit 2 is 1. An accepted general call sets status bit 5, and each START clears that bit.
- R4: In 10-bit mode, a first byte of 11110, followed by control bits 4:3, followed by a 0, is acknowledged. A second byte equal to own-address bits 7:0 is then acknowledged. After both bytes have matched, a repeated START followed by the same first byte with bit 0 = 1 is acknowledged and enters transmit mode. That read header is refused if no full match has occurred since the last STOP.
- R5: Every acknowledged byte is copied into the data buffer. The copy sets status bit 0 and the interrupt flag (bit 6, which drives `irq`). Status bit 2 is 0 for an address byte and 1 for a data byte.
- R6: A byte that completes while status bit 0 is still 1 gets no acknowledge and leaves the buffer unchanged. It sets status bit 7, and that bit stays set until the host writes the status register.
- R7: A host read of the data buffer (`reg_sel` = 0 with `reg_rd`) clears status bit 0.
- R8: In transmit mode, SCL is held low after each acknowledged byte until the host writes the data buffer. That write also loads the shift register. The byte is sent most significant bit first, and reading the buffer back returns the written value.
- R9: Host writes to the status register change only bits 7 and 6. Bits 5 to 0 ignore the write.
- R10: With control bit 0 cleared, no address is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level from the pad |
| sda_i | input | 1 | SDA line level from the pad |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low |
| reg_sel | input | 2 | Host register select |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe (side effect on buffer only) |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data for the selected register |
| irq | output | 1 | Interrupt flag (status bit 6) |

## Verification
The checker looks at every clock cycle for the following:
- START seen and STOP seen never being 1 together.
- A line never being driven outside a transfer.
- The data buffer holding steady while it is full.
- The overflow flag staying set until a host status write.
- The interrupt flag rising together with buffer-full.
- The data line being free at the moment a clock stretch begins.

Only the bench's scenarios can show that the address decisions are correct in each mode, and that the 10-bit repeated-start read depends on an earlier full match. The same goes for the bit order of transmitted bytes and for the read-only behaviour of the lower status bits.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;

    localparam logic [1:0] REG_BUF  = 2'd0;
    localparam logic [1:0] REG_ADDR = 2'd1;
    localparam logic [1:0] REG_CTRL = 2'd2;
    localparam logic [1:0] REG_STAT = 2'd3;

    localparam logic [4:0] HDR10_PREFIX = 5'b11110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR1,
        ST_ADDR2,
        ST_RX,
        ST_TX,
        ST_SKIP
    } eng_state_t;

    typedef struct packed {
        logic [1:0] addr_hi;
        logic       gc_en;
        logic       ten_bit;
        logic       enable;
    } ctrl_t;

    typedef struct packed {
        logic ovf;
        logic irq;
        logic gc_hit;
        logic stop_seen;
        logic start_seen;
        logic is_data;
        logic tx_mode;
        logic buf_full;
    } status_t;

    function automatic logic hdr10_match(input logic [BYTE_W-1:0] b,
                                         input logic [1:0]        hi);
        return (b[BYTE_W-1 -: 5] == HDR10_PREFIX) && (b[2:1] == hi);
    endfunction

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_ff, sda_ff;
    logic scl_s, scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_q  <= scl_s;
            sda_q  <= sda_s;
        end
    end

    assign scl_s     = scl_ff[STAGES-1];
    assign sda_s     = sda_ff[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_tgt_match.sv
module i2c_tgt_match
    import i2c_tgt_pkg::*;
(
    input  logic              is_second,
    input  logic [BYTE_W-1:0] rx_byte,
    input  ctrl_t             ctrl,
    input  logic [BYTE_W-1:0] own_addr,
    input  logic              ten_ok,
    output logic              hit,
    output logic              to_tx,
    output logic              need_second,
    output logic              is_gc
);
    logic own7, hdr, gc;

    always_comb begin
        own7        = rx_byte[BYTE_W-1:1] == own_addr[BYTE_W-2:0];
        hdr         = hdr10_match(rx_byte, ctrl.addr_hi);
        gc          = ctrl.gc_en && (rx_byte == '0);
        hit         = 1'b0;
        to_tx       = 1'b0;
        need_second = 1'b0;
        is_gc       = 1'b0;
        if (is_second) begin
            hit = rx_byte == own_addr;
        end else if (gc) begin
            hit   = 1'b1;
            is_gc = 1'b1;
        end else if (!ctrl.ten_bit) begin
            hit   = own7;
            to_tx = own7 && rx_byte[0];
        end else if (hdr && !rx_byte[0]) begin
            hit         = 1'b1;
            need_second = 1'b1;
        end else if (hdr && ten_ok) begin
            hit   = 1'b1;
            to_tx = 1'b1;
        end
    end
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl,
    input  logic [BYTE_W-1:0] own_addr,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              buf_wr,
    input  logic              buf_rd,
    input  logic [BYTE_W-1:0] buf_wdata,
    input  logic              stat_wr,
    input  logic [1:0]        stat_wdata,
    output logic [BYTE_W-1:0] buf_q,
    output status_t           stat,
    output logic              scl_oe,
    output logic              sda_oe
);
    localparam int CNT_W = $clog2(BYTE_W + 2);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(BYTE_W + 1);

    eng_state_t        state, nxt_q;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sr;
    logic bf, ovf, irq_f, da, tx_mode, gc_hit, s_bit, p_bit;
    logic sda_drv, scl_hold, ten_ok, mnack, tx_loaded;
    logic m_hit, m_tx, m_second, m_gc, accept;

    i2c_tgt_match u_match (
        .is_second  (state == ST_ADDR2),
        .rx_byte    (sr),
        .ctrl       (ctrl),
        .own_addr   (own_addr),
        .ten_ok     (ten_ok),
        .hit        (m_hit),
        .to_tx      (m_tx),
        .need_second(m_second),
        .is_gc      (m_gc)
    );

    assign accept = (state == ST_RX) || m_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;  nxt_q <= ST_IDLE;
            cnt <= '0;  sr <= '0;  buf_q <= '0;
            bf <= 1'b0;  ovf <= 1'b0;  irq_f <= 1'b0;  da <= 1'b0;
            tx_mode <= 1'b0;  gc_hit <= 1'b0;  s_bit <= 1'b0;  p_bit <= 1'b0;
            sda_drv <= 1'b0;  scl_hold <= 1'b0;  ten_ok <= 1'b0;
            mnack <= 1'b0;  tx_loaded <= 1'b0;
        end else begin
            tx_loaded <= 1'b0;
            if (tx_loaded) scl_hold <= 1'b0;
            if (buf_rd) bf <= 1'b0;
            if (stat_wr) begin
                ovf   <= stat_wdata[1];
                irq_f <= stat_wdata[0];
            end
            if (buf_wr) begin
                buf_q <= buf_wdata;
                sr    <= buf_wdata;
                if (state == ST_TX && scl_hold) begin
                    sda_drv   <= ~buf_wdata[BYTE_W-1];
                    tx_loaded <= 1'b1;
                end
            end

            if (stop_det) begin
                state <= ST_IDLE;  s_bit <= 1'b0;  p_bit <= 1'b1;
                sda_drv <= 1'b0;  scl_hold <= 1'b0;  ten_ok <= 1'b0;
            end else if (start_det) begin
                s_bit <= 1'b1;  p_bit <= 1'b0;  gc_hit <= 1'b0;
                sda_drv <= 1'b0;  scl_hold <= 1'b0;  cnt <= '0;  mnack <= 1'b0;
                state <= ctrl.enable ? ST_ADDR1 : ST_IDLE;
            end else if (scl_rise) begin
                if (state inside {ST_ADDR1, ST_ADDR2, ST_RX, ST_TX}) begin
                    if (cnt < CNT_LAST && state != ST_TX)
                        sr <= {sr[BYTE_W-2:0], sda_s};
                    if (cnt < CNT_ACK) cnt <= cnt + 1'b1;
                    if (state == ST_TX && cnt == CNT_LAST) mnack <= sda_s;
                end
            end else if (scl_fall) begin
                if (state == ST_TX) begin
                    if (cnt == CNT_ACK) begin
                        cnt   <= '0;
                        mnack <= 1'b0;
                        if (mnack) state <= ST_SKIP;
                        else begin
                            scl_hold <= 1'b1;
                            irq_f    <= 1'b1;
                        end
                    end else if (cnt == CNT_LAST) begin
                        sda_drv <= 1'b0;
                    end else if (cnt != '0) begin
                        sda_drv <= ~sr[BYTE_W-2];
                        sr      <= {sr[BYTE_W-2:0], 1'b0};
                    end
                end else if (state inside {ST_ADDR1, ST_ADDR2, ST_RX}) begin
                    if (cnt == CNT_LAST) begin
                        if (!accept) begin
                            nxt_q <= ST_SKIP;
                        end else if (bf) begin
                            ovf   <= 1'b1;
                            nxt_q <= ST_SKIP;
                        end else begin
                            buf_q   <= sr;
                            bf      <= 1'b1;
                            irq_f   <= 1'b1;
                            sda_drv <= 1'b1;
                            da      <= (state == ST_RX);
                            if (state == ST_ADDR1) begin
                                tx_mode <= m_tx;
                                gc_hit  <= m_gc;
                                nxt_q   <= m_second ? ST_ADDR2 : (m_tx ? ST_TX : ST_RX);
                            end else if (state == ST_ADDR2) begin
                                tx_mode <= 1'b0;
                                ten_ok  <= 1'b1;
                                nxt_q   <= ST_RX;
                            end else begin
                                nxt_q <= ST_RX;
                            end
                        end
                    end else if (cnt == CNT_ACK) begin
                        sda_drv <= 1'b0;
                        cnt     <= '0;
                        state   <= nxt_q;
                        if (nxt_q == ST_TX) scl_hold <= 1'b1;
                    end
                end
            end
        end
    end

    always_comb begin
        stat.ovf        = ovf;
        stat.irq        = irq_f;
        stat.gc_hit     = gc_hit;
        stat.stop_seen  = p_bit;
        stat.start_seen = s_bit;
        stat.is_data    = da;
        stat.tx_mode    = tx_mode;
        stat.buf_full   = bf;
    end

    assign scl_oe = scl_hold;
    assign sda_oe = sda_drv;
endmodule

// File: rtl/i2c_target_ctrl.sv
module i2c_target_ctrl
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_oe,
    output logic       sda_oe,
    input  logic [1:0] reg_sel,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq
);
    localparam int CTRL_W = $bits(ctrl_t);

    ctrl_t             ctrl_q;
    logic [BYTE_W-1:0] own_q;
    logic [BYTE_W-1:0] buf_w;
    status_t           stat_w;
    logic sda_s, scl_rise, scl_fall, start_det, stop_det;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            own_q  <= '0;
        end else if (reg_wr) begin
            if (reg_sel == REG_CTRL) ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
            if (reg_sel == REG_ADDR) own_q  <= reg_wdata;
        end
    end

    i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    i2c_tgt_engine u_eng (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl_q),
        .own_addr  (own_q),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .buf_wr    (reg_wr && reg_sel == REG_BUF),
        .buf_rd    (reg_rd && reg_sel == REG_BUF),
        .buf_wdata (reg_wdata),
        .stat_wr   (reg_wr && reg_sel == REG_STAT),
        .stat_wdata(reg_wdata[7:6]),
        .buf_q     (buf_w),
        .stat      (stat_w),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe)
    );

    always_comb begin
        case (reg_sel)
            REG_BUF:  reg_rdata = buf_w;
            REG_ADDR: reg_rdata = own_q;
            REG_CTRL: reg_rdata = 8'(ctrl_q);
            default:  reg_rdata = stat_w;
        endcase
    end

    assign irq = stat_w.irq;
endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk
    import i2c_tgt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              scl_oe,
    input logic              sda_oe,
    input logic [1:0]        reg_sel,
    input logic              reg_wr,
    input status_t           stat_w,
    input logic [BYTE_W-1:0] buf_w
);
    assert_drive_in_transfer_R1: assert property (@(posedge clk) disable iff (rst)
        (sda_oe || scl_oe) |-> stat_w.start_seen);

    assert_start_stop_exclusive_R1: assert property (@(posedge clk) disable iff (rst)
        !(stat_w.start_seen && stat_w.stop_seen));

    assert_flag_with_irq_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_w.buf_full) |-> stat_w.irq);

    assert_no_overwrite_R6: assert property (@(posedge clk) disable iff (rst)
        (stat_w.buf_full && $past(stat_w.buf_full) && !$past(reg_wr && reg_sel == REG_BUF))
        |-> $stable(buf_w));

    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(stat_w.ovf) && !$past(reg_wr && reg_sel == REG_STAT)) |-> stat_w.ovf);

    assert_stretch_sda_free_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_oe) |-> !sda_oe);
endmodule

bind i2c_target_ctrl i2c_tgt_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .scl_oe (scl_oe),
    .sda_oe (sda_oe),
    .reg_sel(reg_sel),
    .reg_wr (reg_wr),
    .stat_w (stat_w),
    .buf_w  (buf_w)
);

// File: tb/i2c_target_ctrl_tb.sv
module i2c_target_ctrl_tb;
    localparam int Q = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic scl_oe, sda_oe, irq;
    logic [1:0] reg_sel = 2'd0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'h00, reg_rdata;
    logic scl_bus, sda_bus;
    int tests = 0, fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    assign scl_bus = m_scl & ~scl_oe;
    assign sda_bus = m_sda & ~sda_oe;

    i2c_target_ctrl u_dut (
        .clk(clk), .rst(rst), .scl_i(scl_bus), .sda_i(sda_bus),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    // {ctrl, own address, first byte, expected acknowledge}
    localparam logic [24:0] VECS [0:6] = '{
        {8'h01, 8'h2A, 8'h54, 1'b1},   // R2 match, write
        {8'h01, 8'h2A, 8'h56, 1'b0},   // R2 mismatch
        {8'h01, 8'h2A, 8'h00, 1'b0},   // R3 general call off
        {8'h05, 8'h2A, 8'h00, 1'b1},   // R3 general call on
        {8'h00, 8'h2A, 8'h54, 1'b0},   // R10 disabled
        {8'h13, 8'h5B, 8'hF4, 1'b1},   // R4 10-bit header
        {8'h13, 8'h5B, 8'hF2, 1'b0}    // R4 wrong upper bits
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic wait_high();
        int n = 0;
        while (scl_bus == 1'b0 && n < 3000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 3000) chk("R8 stretch never released", 8'd0, 8'd1);
    endtask

    task automatic host_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_sel = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_sel = a;
        #1;
        d = reg_rdata;
        reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic i2c_start();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wait_high(); wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic i2c_stop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wait_high(); wq();
        m_sda = 1'b1; wq();
    endtask

    task automatic write_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wq();
            m_scl = 1'b1; wait_high(); wq(); wq();
            m_scl = 1'b0; wq();
        end
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wait_high(); wq();
        ack = ~sda_bus;
        wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic read_byte(input logic nack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq();
            m_scl = 1'b1; wait_high(); wq();
            b[i] = sda_bus;
            wq();
            m_scl = 1'b0;
        end
        wq();
        m_sda = nack; wq();
        m_scl = 1'b1; wait_high(); wq(); wq();
        m_scl = 1'b0; wq();
        m_sda = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] d;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R1 reset state
        host_read(2'd3, d);
        chk("R1 reset status", d, 8'h00);
        chk("R1 reset irq", {7'd0, irq}, 8'h00);
        chk("R1 reset drive", {6'd0, scl_oe, sda_oe}, 8'h00);

        // table walk: address decisions
        for (int v = 0; v < 7; v++) begin
            host_write(2'd2, VECS[v][24:17]);
            host_write(2'd1, VECS[v][16:9]);
            host_write(2'd3, 8'h00);
            i2c_start();
            write_byte(VECS[v][8:1], ack);
            i2c_stop();
            chk($sformatf("R2/R3/R4/R10 ack vector %0d", v), {7'd0, ack}, {7'd0, VECS[v][0]});
            if (VECS[v][0]) begin
                host_read(2'd0, d);
                chk($sformatf("R5 buffer vector %0d", v), d, VECS[v][8:1]);
            end
        end

        // R1, R5, R6, R7, R9 receive path
        host_write(2'd2, 8'h01);
        host_write(2'd1, 8'h2A);
        host_write(2'd3, 8'h00);
        i2c_start();
        host_read(2'd3, d);
        chk("R1 start bit", d, 8'h08);
        write_byte(8'h54, ack);
        chk("R2 ack own write", {7'd0, ack}, 8'h01);
        host_read(2'd3, d);
        chk("R5 address flags", d, 8'h49);
        chk("R5 irq pin", {7'd0, irq}, 8'h01);
        host_read(2'd0, d);
        chk("R5 address in buffer", d, 8'h54);
        host_read(2'd3, d);
        chk("R7 read clears full", d, 8'h48);
        write_byte(8'hA5, ack);
        chk("R5 data ack", {7'd0, ack}, 8'h01);
        host_read(2'd3, d);
        chk("R5 data flags", d, 8'h4D);
        write_byte(8'h3C, ack);
        chk("R6 overflow nack", {7'd0, ack}, 8'h00);
        host_read(2'd3, d);
        chk("R6 overflow flag", d, 8'hCD);
        host_read(2'd0, d);
        chk("R6 buffer kept", d, 8'hA5);
        i2c_stop();
        host_read(2'd3, d);
        chk("R1 stop bit", d, 8'hD4);
        host_write(2'd3, 8'h3F);
        host_read(2'd3, d);
        chk("R9 low bits read-only", d, 8'h14);
        chk("R9 irq cleared", {7'd0, irq}, 8'h00);
        host_write(2'd3, 8'hC0);
        host_read(2'd3, d);
        chk("R9 upper bits writable", d, 8'hD4);
        host_write(2'd3, 8'h00);

        // R8 transmit with clock stretching
        i2c_start();
        write_byte(8'h55, ack);
        chk("R2 ack own read", {7'd0, ack}, 8'h01);
        host_read(2'd3, d);
        chk("R2 transmit flags", d, 8'h4B);
        host_read(2'd0, d);
        m_scl = 1'b1;
        repeat (40) @(negedge clk);
        chk("R8 clock stretched", {7'd0, scl_bus}, 8'h00);
        host_write(2'd0, 8'hC3);
        read_byte(1'b0, d);
        chk("R8 first byte", d, 8'hC3);
        host_read(2'd0, d);
        chk("R8 write loads buffer", d, 8'hC3);
        host_write(2'd0, 8'h81);
        read_byte(1'b1, d);
        chk("R8 second byte", d, 8'h81);
        i2c_stop();

        // R4 10-bit sequence
        host_write(2'd2, 8'h13);
        host_write(2'd1, 8'h5B);
        host_write(2'd3, 8'h00);
        i2c_start();
        write_byte(8'hF4, ack);
        chk("R4 header ack", {7'd0, ack}, 8'h01);
        host_read(2'd0, d);
        write_byte(8'h5B, ack);
        chk("R4 low byte ack", {7'd0, ack}, 8'h01);
        host_read(2'd0, d);
        chk("R4 low byte buffered", d, 8'h5B);
        write_byte(8'h11, ack);
        chk("R4 data ack", {7'd0, ack}, 8'h01);
        host_read(2'd0, d);
        i2c_start();
        write_byte(8'hF5, ack);
        chk("R4 read header after match", {7'd0, ack}, 8'h01);
        host_read(2'd3, d);
        chk("R4 transmit direction", d & 8'h02, 8'h02);
        host_read(2'd0, d);
        host_write(2'd0, 8'h6E);
        read_byte(1'b1, d);
        chk("R4 10-bit read data", d, 8'h6E);
        i2c_stop();
        i2c_start();
        write_byte(8'hF4, ack);
        host_read(2'd0, d);
        write_byte(8'h5C, ack);
        chk("R4 low byte mismatch", {7'd0, ack}, 8'h00);
        i2c_stop();
        i2c_start();
        write_byte(8'hF5, ack);
        chk("R4 read header refused", {7'd0, ack}, 8'h00);
        i2c_stop();

        // R3 general call sets flag, START clears it
        host_write(2'd2, 8'h05);
        host_write(2'd1, 8'h2A);
        i2c_start();
        write_byte(8'h00, ack);
        host_read(2'd3, d);
        chk("R3 general call flag", d & 8'h20, 8'h20);
        host_read(2'd0, d);
        i2c_start();
        host_read(2'd3, d);
        chk("R3 start clears flag", d & 8'h20, 8'h00);
        i2c_stop();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule